// File: doc/BRIEF.md
# Programmable Chip-Select with Interrupt-Acknowledge Decoding

This block is one chip-select channel for an external bus with a 24-bit address and 16-bit data. Software programs a base register (address field plus a block-size code) and an option register (byte lanes, direction, address space, response kind and interrupt level). On every bus cycle the channel compares the address, function code, direction and active byte lanes against those fields. When the address strobe falls on a matching cycle, it drives an active-low chip-select and, if programmed to, ends the cycle itself with a 16-bit or 8-bit port acknowledge or with an autovector request.

In its interrupt-acknowledge mode the channel matches only CPU-space cycles (function code all ones) whose priority level on address bits 3..1 equals the programmed level. With the base field set to all ones and a block of 64 KB or less, the space-type nibble on address bits 19..16 also takes part in the compare. When an on-chip module owns the level being acknowledged, it supplies its own vector and acknowledge, and the channel stays silent. The block also holds the 2-bit pin-assignment fields of the eleven chip-select pins. Their values at reset come partly from constants and partly from strap levels sampled during reset.

Top module: `csel_iack_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, cs_n and avec_n are 1 and dsack_n is 2'b11. Base and option both reset to zero, so no cycle matches until software writes the option register.
- R2: While reset is held, pin-assignment field k occupies pin_assign[2k+1:2k]. Its low bit loads 1. Its high bit loads strap_lines[k] for k < 7, and strap_lines[6] for fields 7 to 10.
- R3: A write with reg_sel=2 loads pin_assign[15:0] from reg_wdata. A write with reg_sel=3 loads pin_assign[21:16] from reg_wdata[5:0]. Writes to the base register (reg_sel=0) and option register (reg_sel=1) leave pin_assign unchanged.
- R4: Base bits [15:3] are compared with bus_addr[23:11]. Base bits [2:0] select the block size as codes 0..7 = 2K, 8K, 16K, 64K, 128K, 256K, 512K, 1M bytes. Address bits below the block size are excluded from the compare, and a mismatch in any compared bit gives no chip-select.
- R5: Option bits [7:6] select the space. 0 matches user cycles (bus_fc[2]=0). 1 matches supervisor cycles that are not CPU space. 2 matches any cycle that is not CPU space. 3 is interrupt-acknowledge mode.
- R6: Option bits [3:2] give direction: bit 2 allows reads (bus_rd=1) and bit 3 allows writes. Option bits [1:0] give byte lanes: bit 1 matches an active lane_hi and bit 0 matches an active lane_lo. A cycle matches only if both its direction and at least one of its active lanes are allowed.
- R7: In interrupt-acknowledge mode only cycles with bus_fc=3'b111 match. Option bits [10:8] give the level: 0 accepts any level, and a nonzero value must equal bus_addr[3:1].
- R8: A CPU-space cycle (bus_fc=3'b111) whose strobe falls while internal_iack_owner is high gives cs_n=1, avec_n=1 and dsack_n=2'b11. The owner input has no effect on other cycles.
- R9: Outputs change one clock after the edge that first sees as_n low with a match. They hold while as_n stays low and release one clock after the edge that sees as_n high. A match that appears while as_n is already low does not assert anything.
- R10: Option bits [5:4] select the response. 0 gives chip-select only. 1 also drives avec_n=0. 2 gives dsack_n=2'b01, a 16-bit port. 3 gives dsack_n=2'b10, an 8-bit port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 base, 1 option, 2 pin-assign low, 3 pin-assign high |
| reg_wdata | input | 16 | Register write data |
| strap_lines | input | 7 | Data-line levels sampled during reset |
| bus_addr | input | 24 | Bus cycle address |
| bus_fc | input | 3 | Bus cycle function code |
| bus_rd | input | 1 | 1 for a read cycle |
| lane_hi | input | 1 | Upper byte lane active |
| lane_lo | input | 1 | Lower byte lane active |
| as_n | input | 1 | Address strobe, active low |
| internal_iack_owner | input | 1 | An on-chip module owns the level being acknowledged |
| cs_n | output | 1 | Chip-select, active low |
| avec_n | output | 1 | Autovector request, active low |
| dsack_n | output | 2 | Port-size acknowledge, active low |
| pin_assign | output | 22 | Eleven 2-bit pin-assignment fields |

## Verification
The bench builds the block with its default parameters: a 24-bit address, 16-bit registers, eleven pin fields and seven strap lines. This keeps the whole option space small enough to sweep. It covers all eight block sizes at their edges, every space mode against every function code, and every direction and lane field against every strobe pattern. It also covers every programmed level against every acknowledged level with and without an on-chip owner, and several strap patterns through reset. For each cycle the bench computes the expected chip-select and acknowledge from shifted address compares and the option fields.

// File: rtl/csel_pkg.sv
// Shared types for the chip-select channel.
// Assumes the option register layout documented in the brief.
package csel_pkg;

    typedef enum logic [1:0] {
        RESP_NONE = 2'b00,
        RESP_AVEC = 2'b01,
        RESP_DS16 = 2'b10,
        RESP_DS8  = 2'b11
    } resp_e;

    typedef enum logic [1:0] {
        SP_USER = 2'b00,
        SP_SUPV = 2'b01,
        SP_ANY  = 2'b10,
        SP_IACK = 2'b11
    } space_e;

    typedef struct packed {
        logic [2:0] ipl;
        space_e     space;
        resp_e      resp;
        logic [1:0] rw;
        logic [1:0] lane;
    } opt_t;

    localparam int OPT_W = 11;

    // Lowest compared address bit for a block-size code.
    function automatic logic [4:0] blk_lsb(input logic [2:0] code);
        case (code)
            3'd0:    blk_lsb = 5'd11;
            3'd1:    blk_lsb = 5'd13;
            3'd2:    blk_lsb = 5'd14;
            3'd3:    blk_lsb = 5'd16;
            3'd4:    blk_lsb = 5'd17;
            3'd5:    blk_lsb = 5'd18;
            3'd6:    blk_lsb = 5'd19;
            default: blk_lsb = 5'd20;
        endcase
    endfunction

endpackage

// File: rtl/csel_regs.sv
// Base, option and pin-assignment registers.
// Assumes NUM_CS > DATA_W/2, so the pin fields need a second write word.
// The pin fields load their defaults from strap levels while reset is held.
module csel_regs
    import csel_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_CS  = 11,
    parameter int STRAP_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          sel,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STRAP_W-1:0]  strap,
    output logic [DATA_W-1:0]   base_q,
    output opt_t                opt_q,
    output logic [2*NUM_CS-1:0] pa_q
);
    localparam int PA_W  = 2 * NUM_CS;
    localparam int PA_HI = PA_W - DATA_W;

    logic [PA_W-1:0] pa_rst;

    // Build the reset value of each pin field from constants and straps.
    for (genvar k = 0; k < NUM_CS; k++) begin : g_pa_rst
        localparam int SI = (k < STRAP_W) ? k : STRAP_W - 1;
        assign pa_rst[2*k]   = 1'b1;
        assign pa_rst[2*k+1] = strap[SI];
    end

    // Register writes and synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            opt_q  <= '0;
            pa_q   <= pa_rst;
        end else if (we) begin
            case (sel)
                2'd0: base_q <= wdata;
                2'd1: opt_q  <= opt_t'(wdata[OPT_W-1:0]);
                2'd2: pa_q[DATA_W-1:0] <= wdata;
                default: pa_q[PA_W-1:DATA_W] <= wdata[PA_HI-1:0];
            endcase
        end
    end

    assert_pa_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && sel[1]) |=> $stable(pa_q));

endmodule

// File: rtl/csel_match.sv
// Combinational compare of a bus cycle against the base and option fields.
// Assumes the compared base bits are [DATA_W-1:3] and map to address bits
// ADDR_W-1 down to ADDR_LSB.
module csel_match
    import csel_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fc,
    input  logic              rd,
    input  logic              lane_hi,
    input  logic              lane_lo,
    input  logic [DATA_W-1:0] base,
    input  opt_t              opt,
    output logic              hit,
    output logic              is_cpu
);
    localparam int ADDR_LSB = 11;
    localparam int CMP_W    = ADDR_W - ADDR_LSB;

    logic [4:0]       lsb;
    logic [CMP_W-1:0] eq_bits;
    logic             addr_ok, space_ok, rw_ok, lane_ok;
    logic             unused_addr_bits;

    assign lsb = blk_lsb(base[2:0]);

    // Per-bit compare; bits under the block size always agree.
    for (genvar j = 0; j < CMP_W; j++) begin : g_cmp
        assign eq_bits[j] = (lsb > 5'(ADDR_LSB + j)) || (addr[ADDR_LSB+j] == base[3+j]);
    end

    assign addr_ok          = &eq_bits;
    assign is_cpu           = (fc == 3'b111);
    assign unused_addr_bits = ^{addr[ADDR_LSB-1:4], addr[0]};

    // Space qualifier per mode.
    always_comb begin
        case (opt.space)
            SP_USER: space_ok = !fc[2];
            SP_SUPV: space_ok = fc[2] && !is_cpu;
            SP_ANY:  space_ok = !is_cpu;
            default: space_ok = is_cpu && ((opt.ipl == 3'd0) || (addr[3:1] == opt.ipl));
        endcase
    end

    assign rw_ok   = rd ? opt.rw[0] : opt.rw[1];
    assign lane_ok = (lane_hi && opt.lane[1]) || (lane_lo && opt.lane[0]);
    assign hit     = addr_ok && space_ok && rw_ok && lane_ok;

endmodule

// File: rtl/csel_resp.sv
// Strobe-edge response sequencer: starts on the clock that first sees the
// strobe low with a match, holds until the strobe is seen high.
// Assumes the match inputs are stable while the strobe falls.
module csel_resp
    import csel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       as_n,
    input  logic       hit,
    input  logic       is_cpu,
    input  logic       owner,
    input  resp_e      resp,
    output logic       cs_n,
    output logic       avec_n,
    output logic [1:0] dsack_n
);
    logic  as_n_q;
    logic  active;
    resp_e kind;
    logic  start;

    assign start = !as_n && as_n_q && hit && !(is_cpu && owner);

    // Remember the previous strobe level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) as_n_q <= 1'b1;
        else        as_n_q <= as_n;
    end

    // Track the active response for the current cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            kind   <= RESP_NONE;
        end else if (as_n) begin
            active <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            kind   <= resp;
        end
    end

    // Decode the pins from the active response.
    always_comb begin
        cs_n    = !active;
        avec_n  = !(active && kind == RESP_AVEC);
        dsack_n = 2'b11;
        if (active && kind == RESP_DS16) dsack_n = 2'b01;
        if (active && kind == RESP_DS8)  dsack_n = 2'b10;
    end

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> cs_n);
    assert_owner_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n_q && !as_n && is_cpu && owner) |=> (cs_n && avec_n && dsack_n == 2'b11));
    assert_miss_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n_q && !as_n && !hit) |=> cs_n);
    assert_ack_with_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!avec_n || dsack_n != 2'b11) |-> !cs_n);
    assert_one_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !avec_n |-> (dsack_n == 2'b11));
    assert_dsack_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dsack_n != 2'b00);

endmodule

// File: rtl/csel_iack_unit.sv
// Top of the chip-select channel: registers, cycle compare and response.
// Assumes a single bus master and an address strobe synchronous to clk.
module csel_iack_unit
    import csel_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int NUM_CS  = 11,
    parameter int STRAP_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [STRAP_W-1:0]  strap_lines,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [2:0]          bus_fc,
    input  logic                bus_rd,
    input  logic                lane_hi,
    input  logic                lane_lo,
    input  logic                as_n,
    input  logic                internal_iack_owner,
    output logic                cs_n,
    output logic                avec_n,
    output logic [1:0]          dsack_n,
    output logic [2*NUM_CS-1:0] pin_assign
);
    logic [DATA_W-1:0] base_q;
    opt_t              opt_q;
    logic              hit, is_cpu;

    csel_regs #(.DATA_W(DATA_W), .NUM_CS(NUM_CS), .STRAP_W(STRAP_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
        .strap(strap_lines), .base_q(base_q), .opt_q(opt_q), .pa_q(pin_assign)
    );

    csel_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
        .addr(bus_addr), .fc(bus_fc), .rd(bus_rd), .lane_hi(lane_hi),
        .lane_lo(lane_lo), .base(base_q), .opt(opt_q), .hit(hit), .is_cpu(is_cpu)
    );

    csel_resp resp_i (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .hit(hit), .is_cpu(is_cpu),
        .owner(internal_iack_owner), .resp(opt_q.resp),
        .cs_n(cs_n), .avec_n(avec_n), .dsack_n(dsack_n)
    );

endmodule

// File: tb/csel_iack_unit_tb.sv
`timescale 1ns/100ps
module csel_iack_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [6:0]  strap_lines = '0;
    logic [23:0] bus_addr = '0;
    logic [2:0]  bus_fc = '0;
    logic        bus_rd = 1'b1;
    logic        lane_hi = 1'b0, lane_lo = 1'b0;
    logic        as_n = 1'b1;
    logic        internal_iack_owner = 1'b0;
    logic        cs_n, avec_n;
    logic [1:0]  dsack_n;
    logic [21:0] pin_assign;

    int checks = 0;
    int fails  = 0;
    logic [15:0] cur_base = '0, cur_opt = '0;

    always #2.5 clk = ~clk;

    csel_iack_unit dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .strap_lines(strap_lines), .bus_addr(bus_addr),
        .bus_fc(bus_fc), .bus_rd(bus_rd), .lane_hi(lane_hi), .lane_lo(lane_lo),
        .as_n(as_n), .internal_iack_owner(internal_iack_owner),
        .cs_n(cs_n), .avec_n(avec_n), .dsack_n(dsack_n), .pin_assign(pin_assign)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_opt(input int ipl, input int sp, input int rsp,
                                           input int rw, input int ln);
        return {5'b0, 3'(ipl), 2'(sp), 2'(rsp), 2'(rw), 2'(ln)};
    endfunction

    // Expected match computed from the requirement fields.
    function automatic logic exp_hit(input logic [23:0] a, input logic [2:0] f,
                                     input logic rd, input logic hi, input logic lo,
                                     input logic own);
        int lsb;
        logic cpu, sp_ok, a_ok, rw_ok, ln_ok;
        case (cur_base[2:0])
            3'd0: lsb = 11; 3'd1: lsb = 13; 3'd2: lsb = 14; 3'd3: lsb = 16;
            3'd4: lsb = 17; 3'd5: lsb = 18; 3'd6: lsb = 19; default: lsb = 20;
        endcase
        a_ok = ((a >> lsb) == ({cur_base[15:3], 11'b0} >> lsb));
        cpu  = (f == 3'b111);
        case (cur_opt[7:6])
            2'd0: sp_ok = (f[2] == 1'b0);
            2'd1: sp_ok = f[2] && !cpu;
            2'd2: sp_ok = !cpu;
            default: sp_ok = cpu && (cur_opt[10:8] == 3'd0 || cur_opt[10:8] == a[3:1]);
        endcase
        rw_ok = rd ? cur_opt[2] : cur_opt[3];
        ln_ok = (hi && cur_opt[1]) || (lo && cur_opt[0]);
        return a_ok && sp_ok && rw_ok && ln_ok && !(cpu && own);
    endfunction

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (s == 2'd0) cur_base = d;
        if (s == 2'd1) cur_opt  = d;
    endtask

    task automatic do_reset(input logic [6:0] s);
        @(negedge clk);
        rst_n = 1'b0; strap_lines = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_base = '0; cur_opt = '0;
        @(negedge clk);
    endtask

    // One full strobe cycle; checks pins against the computed expectation.
    task automatic bus_cycle(input logic [23:0] a, input logic [2:0] f, input logic rd,
                             input logic hi, input logic lo, input logic own,
                             input string req);
        logic h;
        logic [1:0] ed;
        @(negedge clk);
        bus_addr = a; bus_fc = f; bus_rd = rd; lane_hi = hi; lane_lo = lo;
        internal_iack_owner = own; as_n = 1'b0;
        #1 check("R9 not before edge", {31'b0, cs_n}, 32'd1);
        h  = exp_hit(a, f, rd, hi, lo, own);
        ed = 2'b11;
        if (h && cur_opt[5:4] == 2'd2) ed = 2'b01;
        if (h && cur_opt[5:4] == 2'd3) ed = 2'b10;
        @(negedge clk);
        check({req, " cs_n"}, {31'b0, cs_n}, {31'b0, !h});
        check({req, " avec_n"}, {31'b0, avec_n}, {31'b0, !(h && cur_opt[5:4] == 2'd1)});
        check({req, " dsack_n"}, {30'b0, dsack_n}, {30'b0, ed});
        @(negedge clk);
        check("R9 hold", {31'b0, cs_n}, {31'b0, !h});
        as_n = 1'b1;
        @(negedge clk);
        check("R9 release", {29'b0, cs_n, dsack_n}, 32'd7);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [21:0] epa;
        logic [23:0] ba;
        int lsb;
        logic [6:0] straps [4];
        straps[0] = 7'h00; straps[1] = 7'h7F; straps[2] = 7'h53; straps[3] = 7'h2C;

        // R1 and R2: reset state over several strap patterns.
        for (int s = 0; s < 4; s++) begin
            do_reset(straps[s]);
            for (int k = 0; k < 11; k++) begin
                epa[2*k]   = 1'b1;
                epa[2*k+1] = straps[s][(k < 7) ? k : 6];
            end
            check("R2 pin defaults", {10'b0, pin_assign}, {10'b0, epa});
            check("R1 idle pins", {29'b0, cs_n, avec_n, dsack_n}, 32'hF);
        end
        bus_cycle(24'h000000, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, "R1 no match after reset");

        // R3: pin-assignment writes and isolation.
        wr(2'd2, 16'hA5C3);
        check("R3 low word", {10'b0, pin_assign}, {10'b0, epa[21:16], 16'hA5C3});
        wr(2'd3, 16'hFFED);
        check("R3 high word", {10'b0, pin_assign}, {10'b0, 6'h2D, 16'hA5C3});
        wr(2'd0, 16'h1234);
        wr(2'd1, 16'h0456);
        check("R3 untouched", {10'b0, pin_assign}, {10'b0, 6'h2D, 16'hA5C3});

        // R4: block sizes at their edges.
        wr(2'd1, mk_opt(0, 2, 2, 3, 3));
        for (int c = 0; c < 8; c++) begin
            wr(2'd0, {13'h15A3, 3'(c)});
            ba = {13'h15A3, 11'b0};
            case (c)
                0: lsb = 11; 1: lsb = 13; 2: lsb = 14; 3: lsb = 16;
                4: lsb = 17; 5: lsb = 18; 6: lsb = 19; default: lsb = 20;
            endcase
            bus_cycle(ba, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, "R4 base");
            bus_cycle(ba | 24'((1 << lsb) - 1), 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, "R4 block top");
            bus_cycle(ba ^ 24'(1 << lsb), 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, "R4 outside");
            bus_cycle(ba ^ 24'h800000, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, "R4 msb differs");
        end

        // R5: space modes against all function codes.
        wr(2'd0, {13'h0042, 3'd2});
        for (int sp = 0; sp < 3; sp++) begin
            wr(2'd1, mk_opt(0, sp, 0, 3, 3));
            for (int f = 0; f < 8; f++)
                bus_cycle({13'h0042, 11'h3A5}, 3'(f), 1'b1, 1'b1, 1'b0, 1'b0, "R5 space");
        end

        // R6: direction and lane fields against strobe patterns.
        for (int rw = 0; rw < 4; rw++)
            for (int ln = 0; ln < 4; ln++) begin
                wr(2'd1, mk_opt(0, 2, 3, rw, ln));
                for (int rd = 0; rd < 2; rd++)
                    for (int p = 0; p < 4; p++)
                        bus_cycle({13'h0042, 11'h010}, 3'b001, 1'(rd), p[1], p[0], 1'b0,
                                  "R6 rw/lane");
            end

        // R7 and R8: interrupt-acknowledge levels with and without an owner.
        wr(2'd0, 16'hFFFB);
        for (int ipl = 0; ipl < 8; ipl++) begin
            wr(2'd1, mk_opt(ipl, 3, 1, 1, 1));
            for (int lvl = 1; lvl < 8; lvl++)
                for (int own = 0; own < 2; own++)
                    bus_cycle({20'hFFFFF, 3'(lvl), 1'b1}, 3'b111, 1'b1, 1'b0, 1'b1, 1'(own),
                              own ? "R8 owner" : "R7 level");
        end
        bus_cycle(24'hF0FFF3, 3'b111, 1'b1, 1'b0, 1'b1, 1'b0, "R7 wrong space type");
        bus_cycle(24'hFFFFF3, 3'b110, 1'b1, 1'b0, 1'b1, 1'b0, "R7 not cpu space");
        wr(2'd0, 16'hFFFC);
        bus_cycle(24'hFEFFF3, 3'b111, 1'b1, 1'b0, 1'b1, 1'b0, "R7 type bit excluded");
        wr(2'd1, mk_opt(0, 2, 2, 3, 3));
        bus_cycle(24'hFFF000, 3'b101, 1'b1, 1'b1, 1'b1, 1'b1, "R8 owner ignored");

        // R10: each response kind on a hit.
        for (int r = 0; r < 4; r++) begin
            wr(2'd1, mk_opt(0, 2, r, 3, 3));
            bus_cycle(24'hFFF000, 3'b101, 1'b0, 1'b1, 1'b1, 1'b0, "R10 response");
        end

        // R9: a match that appears while the strobe is already low.
        wr(2'd1, mk_opt(0, 2, 1, 3, 0));
        @(negedge clk);
        bus_addr = 24'hFFF000; bus_fc = 3'b101; bus_rd = 1'b1;
        lane_hi = 1'b1; lane_lo = 1'b1; internal_iack_owner = 1'b0; as_n = 1'b0;
        @(negedge clk);
        check("R9 miss at strobe", {31'b0, cs_n}, 32'd1);
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = mk_opt(0, 2, 1, 3, 3);
        @(negedge clk);
        reg_we = 1'b0; cur_opt = mk_opt(0, 2, 1, 3, 3);
        @(negedge clk);
        check("R9 late match ignored", {30'b0, cs_n, avec_n}, 32'd3);
        as_n = 1'b1;
        @(negedge clk);
        bus_cycle(24'hFFF000, 3'b101, 1'b1, 1'b1, 1'b1, 1'b0, "R9 next strobe");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule